// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the slave side of a serial byte memory. A host selects it with an active-low select line and clocks commands in on a serial clock. Each command starts with an 8-bit command byte, sent most significant bit first. Array commands follow it with a two-byte address, of which the low 15 bits are used, and then any number of data bytes. After every byte the address steps up by one. It rolls over from 7FFFh to 0000h. A small status byte holds three things: a write-enable latch, two block-protect bits, and an enable for the hardware status lock.

The serial pins are oversampled by a fast system clock. Each pin passes through a synchronizer, and edges of the serial clock are found by comparing successive samples. Because of this, the serial clock may run at any rate well below the system clock, and it may stop for any length of time. An active-low pause input freezes a transfer at the exact bit it has reached. An active-low lock input guards only the status byte, never the array.

Storage is a parameterised array indexed by the low `STORE_AW` bits of the 15-bit address. With `STORE_AW = 15` it holds the full 32768 x 8. The default is kept small, so higher addresses alias onto it.

Top module: `sermem_slave`

## Requirements
- R1: Command 03h followed by a 16-bit address (bits 14:0 used) returns the stored bytes MSB first, and command 02h stores the following bytes starting at that address.
- R2: The address advances by one after every data byte of a read or write burst and wraps from 7FFFh to 0000h.
- R3: `miso_oe_o` is high only during the data phase of a 03h or 05h command, from the first falling serial clock edge of that phase, while select is low. It is low during command and address bytes and whenever select is high.
- R4: Raising select ends any command. Every command byte needs a new select falling edge, so bytes sent after a complete command or after an undefined command byte have no effect until select rises.
- R5: Command 06h sets the write-enable latch (status bit 1) and 04h clears it. Array and status writes take effect only while it is set, and it clears when select rises after any 02h or 01h command.
- R6: Command 05h returns the status byte {bit7 lock-enable, bits 6:4 zero, bits 3:2 protect, bit1 latch, bit0 zero}, repeated for as long as clocks continue.
- R7: Command 01h loads status bits 7 and 3:2 from its data byte. It is refused when bit 7 is already set and `lock_n_i` is low.
- R8: `lock_n_i` low has no effect on array writes.
- R9: Protect bits 00 block nothing, 01 block 6000h-7FFFh, 10 block 4000h-7FFFh and 11 block every address. A blocked byte is not written, but the address still advances.
- R10: While `pause_n_i` is low, serial clock and select edges are ignored and `miso_oe_o` is low. After release the transfer resumes at the bit it had reached.
- R11: `mosi_i` is captured on rising serial clock edges, and `miso_o` changes only on falling serial clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_i | input | 1 | Active-low slave select |
| ser_clk_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data in |
| pause_n_i | input | 1 | Active-low pause; change only while serial clock is low |
| lock_n_i | input | 1 | Active-low status write lock |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for `miso_o`; low means high impedance |

## Verification
Every pin passes two synchronizer flops and the edge-detect register before any state moves. A serial clock edge therefore shows up in `miso_o`, `miso_oe_o` or stored state on the third system clock edge after the pin changes. The bench holds each serial clock level for four system clocks and samples `miso_o` just before it drives the next rising edge, so every read bit, address step and pause release has settled by the time it is checked. The enable checks only start after select has been high, or pause low, for four cycles. Status and array effects are observed through later 05h and 03h commands, which are compared byte by byte against a behavioural model.

// File: rtl/sermem_pkg.sv
// Shared command codes, phase encoding and status bit positions for the
// serial memory slave. Assumes byte-wide commands sent MSB first.
package sermem_pkg;

    localparam logic [7:0] CMD_LATCH_SET = 8'h06;
    localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;
    localparam logic [7:0] CMD_READ      = 8'h03;
    localparam logic [7:0] CMD_WRITE     = 8'h02;

    localparam int ST_LATCH = 1;
    localparam int ST_PROT0 = 2;
    localparam int ST_LOCKE = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_SWR,
        PH_SRD,
        PH_SKIP
    } phase_t;

endpackage

// File: rtl/sermem_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; each bit resets to its own idle level.
module sermem_sync #(
    parameter int          WIDTH   = 5,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe;

        // Shift the raw pin through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {STAGES{RST_VAL[g]}};
            else        pipe <= {pipe[STAGES-2:0], din[g]};
        end

        assign dout[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/sermem_guard.sv
// Decodes the protect field into a write block for one address.
// Assumes the protected region always ends at the top of the address space.
module sermem_guard #(
    parameter int AW = 15
) (
    input  logic [1:0]    prot,
    input  logic [AW-1:0] addr,
    output logic          blocked
);

    // Compare the top address bits against the selected region.
    always_comb begin
        unique case (prot)
            2'b00:   blocked = 1'b0;
            2'b01:   blocked = (addr[AW-1:AW-2] == 2'b11);
            2'b10:   blocked = addr[AW-1];
            default: blocked = 1'b1;
        endcase
    end

endmodule

// File: rtl/sermem_status.sv
// Status byte: write-enable latch, protect field, lock enable.
// Assumes set and clear never arrive together with a write request.
module sermem_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_latch,
    input  logic       clr_latch,
    input  logic       wr_req,
    input  logic       wr_locke,
    input  logic [1:0] wr_prot,
    input  logic       lock_n,
    output logic       latch,
    output logic [1:0] prot,
    output logic       locke,
    output logic [7:0] stat_byte
);

    import sermem_pkg::*;

    logic wr_ok;

    // A status write needs the latch and must not be hardware-locked.
    assign wr_ok = wr_req && latch && !(locke && !lock_n);

    // Hold the latch; clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n)         latch <= 1'b0;
        else if (clr_latch) latch <= 1'b0;
        else if (set_latch) latch <= 1'b1;
    end

    // Load the non-volatile style fields on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot  <= 2'b00;
            locke <= 1'b0;
        end else if (wr_ok) begin
            prot  <= wr_prot;
            locke <= wr_locke;
        end
    end

    // Assemble the byte returned by a status read.
    always_comb begin
        stat_byte               = 8'h00;
        stat_byte[ST_LATCH]     = latch;
        stat_byte[ST_PROT0+:2]  = prot;
        stat_byte[ST_LOCKE]     = locke;
    end

endmodule

// File: rtl/sermem_store.sv
// Byte storage with one synchronous write port and one combinational read.
// Assumes the caller has already folded addresses onto the index width.
module sermem_store #(
    parameter int IDX_W = 10,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] cells [DEPTH];

    // Store one byte per accepted write.
    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    assign rdata = cells[ridx];

endmodule

// File: rtl/sermem_slave.sv
// Serial memory slave top: oversamples the serial pins, decodes commands,
// steps the address and drives the serial output. Assumes the system clock
// is at least eight times faster than the serial clock.
module sermem_slave
    import sermem_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int STORE_AW = 10,
    parameter int SYNC_N   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_i,
    input  logic ser_clk_i,
    input  logic mosi_i,
    input  logic pause_n_i,
    input  logic lock_n_i,
    output logic miso_o,
    output logic miso_oe_o
);

    localparam int ADDR_CNT = ((ADDR_W + 7) / 8) * 8;
    localparam int CW       = $clog2(ADDR_CNT);
    localparam int PINS     = 5;

    logic [PINS-1:0] pin_s;
    logic lock_n_s, pause_n_s, sel_n_s, sck_s, mosi_s;
    logic sck_q;
    logic live, rise_evt, fall_evt, end_evt;

    phase_t              phase;
    logic [CW-1:0]       cnt;
    logic [ADDR_W-2:0]   sh;
    logic [ADDR_W-1:0]   inword;
    logic [7:0]          inbyte;
    logic [ADDR_W-1:0]   addr_q, addr_nx;
    logic [7:0]          obuf;
    logic [2:0]          ocnt;
    logic                drv, wr_cmd, rd_mode, so_q, oe_q;
    logic                is_rd, byte_done, addr_step;

    logic                wel, wpen, blocked;
    logic [1:0]          bp;
    logic [7:0]          stat_byte;
    logic                set_wel, clr_wel, st_wr_req, mem_we;
    logic [STORE_AW-1:0] rd_idx;
    logic [7:0]          store_rd;

    sermem_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_N),
        .RST_VAL(5'b11100)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({lock_n_i, pause_n_i, sel_n_i, ser_clk_i, mosi_i}),
        .dout (pin_s)
    );

    assign {lock_n_s, pause_n_s, sel_n_s, sck_s, mosi_s} = pin_s;

    // Remember the previous serial clock sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign live      = !sel_n_s && pause_n_s;
    assign rise_evt  = live && sck_s && !sck_q;
    assign fall_evt  = live && !sck_s && sck_q;
    assign end_evt   = sel_n_s && pause_n_s && (phase != PH_IDLE);

    assign inword    = {sh, mosi_s};
    assign inbyte    = inword[7:0];
    assign addr_nx   = addr_q + 1'b1;
    assign is_rd     = (phase == PH_RDATA) || (phase == PH_SRD);
    assign byte_done = rise_evt && (cnt == CW'(7));
    assign addr_step = (byte_done && phase == PH_WDATA)
                    || (fall_evt && phase == PH_RDATA && ocnt == 3'd7);

    // Derive status and storage strobes from the current bit event.
    always_comb begin
        set_wel   = byte_done && phase == PH_CMD && inbyte == CMD_LATCH_SET;
        clr_wel   = (byte_done && phase == PH_CMD && inbyte == CMD_LATCH_CLR)
                 || (end_evt && wr_cmd);
        st_wr_req = byte_done && phase == PH_SWR;
        mem_we    = byte_done && phase == PH_WDATA && wel && !blocked;
    end

    // Pick the byte to preload: new address at address end, else next one.
    assign rd_idx = (phase == PH_ADDR) ? inword[STORE_AW-1:0]
                                       : addr_nx[STORE_AW-1:0];

    sermem_status status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_latch(set_wel),
        .clr_latch(clr_wel),
        .wr_req   (st_wr_req),
        .wr_locke (inbyte[ST_LOCKE]),
        .wr_prot  (inbyte[ST_PROT0+:2]),
        .lock_n   (lock_n_s),
        .latch    (wel),
        .prot     (bp),
        .locke    (wpen),
        .stat_byte(stat_byte)
    );

    sermem_guard #(.AW(ADDR_W)) guard_i (
        .prot   (bp),
        .addr   (addr_q),
        .blocked(blocked)
    );

    sermem_store #(.IDX_W(STORE_AW), .DW(8)) store_i (
        .clk  (clk),
        .we   (mem_we),
        .widx (addr_q[STORE_AW-1:0]),
        .wdata(inbyte),
        .ridx (rd_idx),
        .rdata(store_rd)
    );

    // Command sequencer: phases, bit counting, address and output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            sh      <= '0;
            addr_q  <= '0;
            obuf    <= '0;
            ocnt    <= '0;
            drv     <= 1'b0;
            wr_cmd  <= 1'b0;
            rd_mode <= 1'b0;
            so_q    <= 1'b0;
        end else if (end_evt) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            drv    <= 1'b0;
            wr_cmd <= 1'b0;
        end else if (phase == PH_IDLE) begin
            if (live) begin
                phase <= PH_CMD;
                cnt   <= '0;
            end
        end else if (rise_evt) begin
            sh  <= inword[ADDR_W-2:0];
            cnt <= cnt + 1'b1;
            unique case (phase)
                PH_CMD: if (cnt == CW'(7)) begin
                    cnt <= '0;
                    unique case (inbyte)
                        CMD_STAT_RD: begin
                            phase <= PH_SRD;
                            obuf  <= stat_byte;
                            ocnt  <= '0;
                        end
                        CMD_STAT_WR: begin
                            phase  <= PH_SWR;
                            wr_cmd <= 1'b1;
                        end
                        CMD_READ: begin
                            phase   <= PH_ADDR;
                            rd_mode <= 1'b1;
                        end
                        CMD_WRITE: begin
                            phase   <= PH_ADDR;
                            rd_mode <= 1'b0;
                            wr_cmd  <= 1'b1;
                        end
                        default: phase <= PH_SKIP;
                    endcase
                end
                PH_ADDR: if (cnt == CW'(ADDR_CNT - 1)) begin
                    cnt    <= '0;
                    addr_q <= inword;
                    if (rd_mode) begin
                        phase <= PH_RDATA;
                        obuf  <= store_rd;
                        ocnt  <= '0;
                    end else begin
                        phase <= PH_WDATA;
                    end
                end
                PH_WDATA: if (cnt == CW'(7)) begin
                    cnt    <= '0;
                    addr_q <= addr_nx;
                end
                PH_SWR: if (cnt == CW'(7)) phase <= PH_SKIP;
                default: ;
            endcase
        end else if (fall_evt && is_rd) begin
            so_q <= obuf[7];
            obuf <= {obuf[6:0], 1'b0};
            ocnt <= ocnt + 1'b1;
            drv  <= 1'b1;
            if (ocnt == 3'd7) begin
                if (phase == PH_RDATA) begin
                    addr_q <= addr_nx;
                    obuf   <= store_rd;
                end else begin
                    obuf <= stat_byte;
                end
            end
        end
    end

    // Output enable: read data phase, once driving, selected and not paused.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= is_rd && (drv || fall_evt) && live && !end_evt;
    end

    assign miso_o    = so_q;
    assign miso_oe_o = oe_q;

endmodule

// File: rtl/sermem_slave_chk.sv
// Property checker for the serial memory slave, attached by bind.
// Assumes it sees the synchronized pins and internal strobes of the top.
module sermem_slave_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n_s,
    input logic              pause_n_s,
    input logic              lock_n_s,
    input logic              fall_evt,
    input logic              end_evt,
    input logic              wr_cmd,
    input logic              wel,
    input logic              wpen,
    input logic [1:0]        bp,
    input logic              mem_we,
    input logic              st_wr_req,
    input logic              addr_step,
    input logic [ADDR_W-1:0] addr_q,
    input logic              miso_o,
    input logic              miso_oe_o
);

    p_quiet_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> !miso_oe_o);

    p_quiet_paused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_n_s |=> !miso_oe_o);

    p_miso_moves_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_evt |=> $stable(miso_o));

    p_latch_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && wr_cmd) |=> !wel);

    p_full_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bp == 2'b11) |-> !mem_we);

    p_addr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_step && addr_q == {ADDR_W{1'b1}}) |=> (addr_q == '0));

    p_status_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_req && wpen && !lock_n_s) |=> ($stable(bp) && wpen));

endmodule

bind sermem_slave sermem_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n_s  (sel_n_s),
    .pause_n_s(pause_n_s),
    .lock_n_s (lock_n_s),
    .fall_evt (fall_evt),
    .end_evt  (end_evt),
    .wr_cmd   (wr_cmd),
    .wel      (wel),
    .wpen     (wpen),
    .bp       (bp),
    .mem_we   (mem_we),
    .st_wr_req(st_wr_req),
    .addr_step(addr_step),
    .addr_q   (addr_q),
    .miso_o   (miso_o),
    .miso_oe_o(miso_oe_o)
);

// File: tb/sermem_slave_tb_top.sv
// Bench for the serial memory slave: drives serial transfers from tasks and
// keeps a behavioural model (associative array and flags) of storage/status.
module sermem_slave_tb_top;

    localparam int DEPTH = 1024;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, sel_n, sck, mosi, pause_n, lock_n;
    logic miso, miso_oe;

    int n_run = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    byte unsigned mem_m [int];
    bit       m_wel;
    bit [1:0] m_bp;
    bit       m_wpen;

    sermem_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_i  (sel_n),
        .ser_clk_i(sck),
        .mosi_i   (mosi),
        .pause_n_i(pause_n),
        .lock_n_i (lock_n),
        .miso_o   (miso),
        .miso_oe_o(miso_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit m_prot(input int a);
        case (m_bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 'h6000;
            2'b10:   return a >= 'h4000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] m_stat();
        return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    // One byte each way; samples just before each rising serial clock edge.
    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output bit oe_all, output bit oe_any);
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wclk(4);
            rx[i]  = miso;
            oe_all = oe_all & miso_oe;
            oe_any = oe_any | miso_oe;
            sck = 1'b1;
            wclk(4);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        sel_n = 1'b0;
        wclk(4);
    endtask

    task automatic cs_hi();
        wclk(4);
        sel_n = 1'b1;
        wclk(6);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] rx; bit a, b;
        cs_lo();
        xfer(op, rx, a, b);
        cs_hi();
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
    endtask

    task automatic wr_burst(input int adr, input byte unsigned q[$]);
        logic [7:0] rx; bit a, b;
        int p = adr;
        cs_lo();
        xfer(8'h02, rx, a, b);
        xfer(8'((adr >> 8) & 'h7F), rx, a, b);
        xfer(8'(adr & 'hFF), rx, a, b);
        foreach (q[k]) begin
            xfer(q[k], rx, a, b);
            if (m_wel && !m_prot(p)) mem_m[p % DEPTH] = q[k];
            p = (p + 1) & 'h7FFF;
        end
        cs_hi();
        m_wel = 1'b0;
    endtask

    task automatic rd_burst(input int adr, input int n, input string req);
        logic [7:0] rx; bit a, b;
        int p = adr;
        cs_lo();
        xfer(8'h03, rx, a, b);
        chk(!b, "R3 oe during command", b, 0);
        xfer(8'((adr >> 8) & 'h7F), rx, a, b);
        xfer(8'(adr & 'hFF), rx, a, b);
        chk(!b, "R3/R11 oe during address", b, 0);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, rx, a, b);
            chk(rx == mem_m[p % DEPTH], req, rx, mem_m[p % DEPTH]);
            chk(a, "R3 oe during read data", a, 1);
            p = (p + 1) & 'h7FFF;
        end
        cs_hi();
    endtask

    task automatic st_write(input logic [7:0] v);
        logic [7:0] rx; bit a, b;
        cs_lo();
        xfer(8'h01, rx, a, b);
        xfer(v, rx, a, b);
        cs_hi();
        if (m_wel && !(m_wpen && !lock_n)) begin
            m_wpen = v[7];
            m_bp   = v[3:2];
        end
        m_wel = 1'b0;
    endtask

    task automatic st_read(input string req);
        logic [7:0] rx; bit a, b;
        cs_lo();
        xfer(8'h05, rx, a, b);
        for (int k = 0; k < 2; k++) begin
            xfer(8'h00, rx, a, b);
            chk(rx == m_stat(), req, rx, m_stat());
        end
        cs_hi();
    endtask

    // Read two bytes, pausing mid-way through the first one.
    task automatic rd_paused(input int adr);
        logic [7:0] rx; bit a, b;
        cs_lo();
        xfer(8'h03, rx, a, b);
        xfer(8'((adr >> 8) & 'h7F), rx, a, b);
        xfer(8'(adr & 'hFF), rx, a, b);
        for (int i = 7; i >= 0; i--) begin
            mosi = 1'b0;
            wclk(4);
            if (i == 4) begin
                pause_n = 1'b0;
                wclk(6);
                chk(!miso_oe, "R10 oe while paused", miso_oe, 0);
                repeat (3) begin
                    sck = 1'b1; wclk(4);
                    sck = 1'b0; wclk(4);
                end
                pause_n = 1'b1;
                wclk(4);
            end
            rx[i] = miso;
            sck = 1'b1;
            wclk(4);
            sck = 1'b0;
        end
        chk(rx == mem_m[adr % DEPTH], "R10 byte across pause", rx, mem_m[adr % DEPTH]);
        xfer(8'h00, rx, a, b);
        chk(rx == mem_m[(adr + 1) % DEPTH], "R10 byte after pause", rx,
            mem_m[(adr + 1) % DEPTH]);
        cs_hi();
    endtask

    // Every clock: enable must be low once deselect or pause has settled.
    int hi_cnt = 0;
    int ps_cnt = 0;
    always @(negedge clk) begin
        hi_cnt = (rst_n && sel_n) ? hi_cnt + 1 : 0;
        ps_cnt = (rst_n && !pause_n) ? ps_cnt + 1 : 0;
        if (hi_cnt >= 4 && !finished) chk(!miso_oe, "R3 oe while deselected", miso_oe, 0);
        if (ps_cnt >= 4 && !finished) chk(!miso_oe, "R10 oe while paused", miso_oe, 0);
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx; bit a, b;
        rst_n = 1'b0; sel_n = 1'b1; sck = 1'b0; mosi = 1'b0;
        pause_n = 1'b1; lock_n = 1'b1;
        m_wel = 1'b0; m_bp = 2'b00; m_wpen = 1'b0;
        wclk(5);
        chk(!miso_oe, "R3 reset enable", miso_oe, 0);
        rst_n = 1'b1;
        wclk(5);
        st_read("R6 reset status");

        // R1 basic burst write and read back
        cmd1(8'h06);
        st_read("R5 latch set by 06h");
        wr_burst('h0010, '{8'h5A, 8'hC3, 8'h0F});
        rd_burst('h0010, 3, "R1/R11 read data");
        st_read("R5 latch cleared after write");

        // R5 write without latch is ignored
        wr_burst('h0010, '{8'hFF});
        rd_burst('h0010, 1, "R5 write without latch");
        cmd1(8'h06);
        cmd1(8'h04);
        st_read("R5 latch cleared by 04h");

        // R2 wrap at top of address space
        cmd1(8'h06);
        wr_burst('h7FFF, '{8'hA1, 8'hB2});
        rd_burst('h7FFF, 2, "R2 wrap read");

        // R4 undefined command, then bytes inside the same select
        cs_lo();
        xfer(8'hAB, rx, a, b);
        xfer(8'h06, rx, a, b);
        xfer(8'h00, rx, a, b);
        chk(!b, "R4 no output after undefined command", b, 0);
        cs_hi();
        st_read("R4 latch untouched after undefined command");
        cs_lo();
        xfer(8'h06, rx, a, b);
        xfer(8'h05, rx, a, b);
        xfer(8'h00, rx, a, b);
        chk(!b, "R4 second command ignored", b, 0);
        cs_hi();
        m_wel = 1'b1;
        st_read("R4 first command took effect");
        cmd1(8'h04);

        // R9 protect regions
        cmd1(8'h06); st_write(8'h04);
        st_read("R7 protect field written");
        cmd1(8'h06); wr_burst('h5FFF, '{8'h11, 8'h22});
        rd_burst('h5FFF, 2, "R9 upper quarter");
        cmd1(8'h06); st_write(8'h08);
        cmd1(8'h06); wr_burst('h3FFF, '{8'h33, 8'h44});
        rd_burst('h3FFF, 2, "R9 upper half");
        cmd1(8'h06); st_write(8'h0C);
        cmd1(8'h06); wr_burst('h0010, '{8'h99});
        rd_burst('h0010, 1, "R9 all blocked");
        cmd1(8'h06); st_write(8'h00);
        st_read("R9 protect cleared");

        // R7 / R8 hardware lock
        cmd1(8'h06); st_write(8'h80);
        lock_n = 1'b0;
        wclk(4);
        cmd1(8'h06); st_write(8'h0C);
        st_read("R7 status write refused under lock");
        cmd1(8'h06); wr_burst('h0020, '{8'h77});
        rd_burst('h0020, 1, "R8 array write under lock");
        lock_n = 1'b1;
        wclk(4);
        cmd1(8'h06); st_write(8'h00);
        st_read("R7 status write after lock release");

        // R10 pause in the middle of a read
        rd_paused('h0010);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule